// File: doc/BRIEF.md
# Paired-Word Instruction Fetch Stash

This block sits between an instruction fetch stage and a memory whose read port is twice the width of an instruction word. Every memory read returns an aligned pair of adjacent words. The fetch stage gets the word it asked for. If that word was the lower one of the pair, the upper one is kept in a one-entry stash. A later request for the stashed address is then answered in the same cycle with no memory traffic.

Sequential fetch therefore needs one memory read for every two instructions. A jump can leave the stashed word unused. It is then overwritten by the next miss, or dropped by a flush. A stashed word is never delivered for an address it does not belong to.

A miss takes two cycles. In the request cycle the block raises the memory read strobe with the pair address. The memory presents the 64-bit pair on the following cycle, and the block answers then. The requester holds its request until `rd_ready` is seen.

Top module: `fetch_pair_buf`

## Requirements
- R1: On a miss, `mem_addr` equals the requested word address with bit 0 forced to 0, and `mem_req` is high for exactly that request cycle.
- R2: A request whose address matches a valid stash entry, with `flush` low, is answered in the same cycle. `rd_ready` and `rd_hit` are both 1, `rd_word` is the stashed word, and `mem_req` stays 0.
- R3: On a miss, `rd_ready` is 0 in the request cycle. In the next cycle `rd_ready` is 1 and `rd_hit` is 0. `rd_word` is then `mem_rdata[31:0]` when request address bit 0 is 0, and `mem_rdata[63:32]` when it is 1.
- R4: A miss to an even address (bit 0 = 0) leaves the stash holding `mem_rdata[63:32]` at the request address plus one. This replaces any earlier stash contents.
- R5: `flush` invalidates the stash, whether it comes in an idle cycle or during a miss. A request presented with `flush` high is treated as a miss.
- R6: A miss to an odd address (bit 0 = 1) leaves the stash empty. The lower word of that pair is not kept.
- R7: After reset the stash is empty, and `rd_ready`, `rd_hit` and `mem_req` are 0 while no request is presented.
- R8: A hit does not use up the stash. Repeated requests to the same stashed address keep hitting.
- R9: With `req_valid` low and no miss outstanding, `mem_req` and `rd_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request strobe, held until `rd_ready` |
| req_addr | input | AW (16) | Requested word address |
| flush | input | 1 | Invalidate the stash |
| mem_rdata | input | 2*DW (64) | Word pair from memory, valid the cycle after `mem_req` |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | AW (16) | Even word address of the pair to read |
| rd_word | output | DW (32) | Returned instruction word |
| rd_ready | output | 1 | `rd_word` is valid this cycle |
| rd_hit | output | 1 | The reply came from the stash |

## Verification
The hardest case to reach is a stale stash entry that must not answer. This happens when `flush` arrives during the second cycle of an even-address miss, so it races the stash fill. It also happens when a jump lands on the odd partner of an old pair after an odd-address miss has cleared the stash. The random stimulus mostly steps to the next address, but now and then jumps back by one or to a nearby address. It raises `flush` on a fraction of requests and idle cycles. This makes such sequences common. Directed cases then cover each one explicitly.

// File: rtl/fetch_pair_buf.sv
module fetch_pair_buf #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic            flush,
  input  logic [2*DW-1:0] mem_rdata,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   rd_word,
  output logic            rd_ready,
  output logic            rd_hit
);
  logic          busy, pend_odd, sv;
  logic [AW-2:0] pend_pair, sv_pair;
  logic [DW-1:0] sv_data;
  logic          hit, miss;

  assign hit      = !busy && req_valid && !flush && sv && ({sv_pair, 1'b1} == req_addr);
  assign miss     = !busy && req_valid && !hit;
  assign mem_req  = miss;
  assign mem_addr = {req_addr[AW-1:1], 1'b0};
  assign rd_hit   = hit;
  assign rd_ready = hit || busy;
  assign rd_word  = hit ? sv_data : (pend_odd ? mem_rdata[2*DW-1:DW] : mem_rdata[DW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend_odd  <= 1'b0;
      pend_pair <= '0;
      sv        <= 1'b0;
      sv_pair   <= '0;
      sv_data   <= '0;
    end else begin
      busy <= miss;
      if (miss) begin
        pend_odd  <= req_addr[0];
        pend_pair <= req_addr[AW-1:1];
      end
      if (flush) sv <= 1'b0;
      else if (busy) begin
        sv      <= !pend_odd;
        sv_pair <= pend_pair;
        sv_data <= mem_rdata[2*DW-1:DW];
      end
    end
  end
endmodule

// File: rtl/fetch_pair_buf_chk.sv
module fetch_pair_buf_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          flush,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          rd_ready,
  input logic          rd_hit
);
  p_pair_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[0] == 1'b0 && mem_addr[AW-1:1] == req_addr[AW-1:1]));
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_hit_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_ready && !mem_req));
  p_miss_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (rd_ready && !rd_hit));
  p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_hit);
  p_odd_no_stash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_addr[0]) |=> ##1 !rd_hit);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !$past(mem_req)) |-> (!mem_req && !rd_ready));
endmodule

bind fetch_pair_buf fetch_pair_buf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .flush(flush), .mem_req(mem_req), .mem_addr(mem_addr),
  .rd_ready(rd_ready), .rd_hit(rd_hit)
);

// File: tb/fetch_pair_buf_test.sv
module fetch_pair_buf_test;
  localparam int AW = 16, DW = 32;
  logic clk = 0, rst_n = 0, req_valid = 0, flush = 0;
  logic [AW-1:0] req_addr = '0;
  logic [2*DW-1:0] mem_rdata = '0;
  logic mem_req, rd_ready, rd_hit;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] rd_word;
  int checks = 0, errors = 0;
  bit m_sv = 0;
  logic [AW-1:0] m_sa = '0;
  logic [DW-1:0] m_sd = '0;

  fetch_pair_buf #(.AW(AW), .DW(DW)) uut (.*);

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] wval(input logic [AW-1:0] a);
    return 32'hC3A50000 ^ (32'(a) * 32'h9E37) ^ {16'(a), 16'h0};
  endfunction

  always @(posedge clk)
    if (mem_req) mem_rdata <= {wval({mem_addr[AW-1:1], 1'b1}), wval({mem_addr[AW-1:1], 1'b0})};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fetch(input logic [AW-1:0] a, input bit fl);
    bit exp_hit;
    exp_hit = !fl && m_sv && (m_sa == a);
    req_valid = 1; req_addr = a; flush = fl;
    #1;
    if (exp_hit) begin
      chk(rd_ready && rd_hit && !mem_req, "R2 hit flags", {rd_ready, rd_hit, mem_req}, 3'b110);
      chk(rd_word == m_sd, "R2/R8 hit word", rd_word, m_sd);
      @(negedge clk);
    end else begin
      chk(mem_req && !rd_ready, "R3 miss strobe", {mem_req, rd_ready}, 2'b10);
      chk(mem_addr == {a[AW-1:1], 1'b0}, "R1 pair addr", mem_addr, {a[AW-1:1], 1'b0});
      @(negedge clk);
      chk(rd_ready && !rd_hit && !mem_req, "R3 reply flags", {rd_ready, rd_hit, mem_req}, 3'b100);
      chk(rd_word == wval(a), a[0] ? "R3 high word" : "R3 low word", rd_word, wval(a));
      @(negedge clk);
      if (fl || a[0]) m_sv = 0;
      else begin m_sv = 1; m_sa = a | 1; m_sd = wval(a | 1); end
    end
    req_valid = 0; flush = 0;
  endtask

  task automatic idle(input bit fl);
    flush = fl;
    #1;
    chk(!mem_req && !rd_ready, "R9 idle quiet", {mem_req, rd_ready}, 2'b00);
    @(negedge clk);
    flush = 0;
    if (fl) m_sv = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    chk(!mem_req && !rd_ready && !rd_hit, "R7 reset idle", {mem_req, rd_ready, rd_hit}, 3'b000);
    @(negedge clk);
    fetch(16'h0011, 0);                          // R7 empty stash: odd addr misses
    fetch(16'h0010, 0);                          // R4 fills stash with 0x11
    fetch(16'h0011, 0);                          // R2 hit
    fetch(16'h0011, 0);                          // R8 repeat hit
    fetch(16'h0020, 0);                          // R4 replace
    fetch(16'h0011, 0);                          // R4 old entry gone: miss
    fetch(16'h0020, 0);
    idle(1);                                     // R5 idle flush
    fetch(16'h0021, 0);                          // R5 miss after flush
    fetch(16'h0030, 0);
    fetch(16'h0031, 1);                          // R5 flush with request
    fetch(16'h0040, 1);                          // R5 flush during even miss
    fetch(16'h0041, 0);
    fetch(16'h0050, 0);
    fetch(16'h0053, 0);                          // R6 odd miss clears stash
    fetch(16'h0051, 0);                          // R6 stale partner not served
    fetch(16'h0052, 0);                          // R6 low half of odd pair not kept
    a = 16'h0100;
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 60) a = a + 1;
      else if (r < 70) a = a - 1;
      else if (r < 85) a = 16'h0100 + 16'($urandom_range(0, 31));
      else a = a;
      if ($urandom_range(0, 9) == 0) idle($urandom_range(0, 1) == 1);
      fetch(a, $urandom_range(0, 11) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule